// File: doc/BRIEF.md
# Byte FIFO Pair with Event Interrupts

This block sits between a register port and an I2C byte engine. It buffers outgoing bytes in a transmit FIFO and incoming bytes in a receive FIFO. Software pushes transmit bytes and pops receive bytes through data registers. The engine pops the transmit side and pushes the receive side through dedicated strobes.

Each FIFO has its own enable and trigger level. A status word reports both fill levels with full and empty flags.

Seven sticky event bits record the following:
- level conditions: transmit almost-empty and receive almost-full;
- misuse: overrun and underrun on either side;
- a trailing event, raised when received bytes have sat untouched for a programmed number of cycles. Software can then drain a short tail without polling.

Software clears event bits by writing ones. A per-bit enable mask gates the events onto one interrupt line.

Top module: `i2c_fifo_pair`

## Requirements
- R1: After reset the control, trailing-count, enable and event registers read 0, both FIFOs are empty, and `irq_o` is low.
- R2: Registers are selected by `reg_addr_i`: 0 control, 1 trailing count (bits 3:0), 2 interrupt enable, 3 event status, 4 FIFO status (read only), 5 transmit data (a write pushes bits 7:0), 6 receive data (a read with `reg_re_i` pops and returns the byte in bits 7:0).
- R3: The FIFO status word holds the TX level in bits 6:0, TX full at bit 7 and TX empty at bit 8. It holds the RX level in bits 22:16, RX full at bit 23 and RX empty at bit 24.
- R4: In the control word, bit 0 enables RX and bit 1 enables TX. The RX trigger sits in bits 10:4 and the TX trigger in bits 22:16. A disabled FIFO is held empty, and pushes or pops to it change nothing and raise no event.
- R5: Each FIFO returns bytes in the order they were pushed, and its level counts accepted pushes minus accepted pops.
- R6: Event bit 0 (TX almost-empty) is set on the cycle after the TX FIFO is enabled with its level at or below the TX trigger.
- R7: Event bit 1 (RX almost-full) is set on the cycle after the RX FIFO is enabled with its level at or above the RX trigger.
- R8: A push into a full FIFO drops the byte and sets bit 3 (TX overrun) or bit 5 (RX overrun).
- R9: A pop from an empty FIFO returns 0x00 and sets bit 2 (TX underrun) or bit 4 (RX underrun).
- R10: While the RX FIFO is enabled and non-empty with no push or pop, an idle counter advances each cycle. Any push or pop, or an empty FIFO, restarts it. Event bit 6 is set exactly N cycles after the last activity, where N is the nonzero trailing count, and only once per idle stretch. A count of 0 never fires.
- R11: Writing the event register clears exactly the bits written as one and keeps the others. An event arriving in the same cycle wins over the clear.
- R12: `irq_o` is high exactly when some event bit is set and its matching enable bit (same position, bits 6:0) is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (pops on the receive-data address) |
| reg_addr_i | input | 3 | Register select |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| tx_pop_i | input | 1 | Engine pops one transmit byte |
| tx_data_o | output | 8 | Head of the transmit FIFO, 0x00 when empty |
| rx_push_i | input | 1 | Engine pushes one received byte |
| rx_data_i | input | 8 | Received byte from the engine |
| irq_o | output | 1 | Interrupt, OR of enabled event bits |

## Verification
The checker watches every cycle for the following:
- a disabled FIFO always empties;
- a rejected push leaves the level unchanged and raises its overrun bit;
- an empty transmit pop yields zero;
- event bits never drop without a clear write;
- the interrupt never rises with an all-zero mask.

Only the directed scenarios can show the rest:
- byte ordering across both FIFOs;
- the exact cycle at which the trailing event fires and the fact that it does not repeat;
- the trigger comparisons at their boundaries;
- the selective effect of a partial clear.

// File: rtl/i2cfp_pkg.sv
package i2cfp_pkg;
  localparam int unsigned ADDR_W  = 3;
  localparam int unsigned LVL_FW  = 7;
  localparam int unsigned NUM_EVT = 7;

  localparam logic [ADDR_W-1:0] RA_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] RA_TRAIL = 3'd1;
  localparam logic [ADDR_W-1:0] RA_IEN   = 3'd2;
  localparam logic [ADDR_W-1:0] RA_ISTS  = 3'd3;
  localparam logic [ADDR_W-1:0] RA_FSTS  = 3'd4;
  localparam logic [ADDR_W-1:0] RA_TXD   = 3'd5;
  localparam logic [ADDR_W-1:0] RA_RXD   = 3'd6;

  localparam int unsigned EV_TX_AE  = 0;
  localparam int unsigned EV_RX_AF  = 1;
  localparam int unsigned EV_TX_UDR = 2;
  localparam int unsigned EV_TX_OVR = 3;
  localparam int unsigned EV_RX_UDR = 4;
  localparam int unsigned EV_RX_OVR = 5;
  localparam int unsigned EV_TRAIL  = 6;
endpackage

// File: rtl/i2cfp_fifo.sv
module i2cfp_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned LVL_W = PTR_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [DW-1:0]    data_i,
  input  logic             pop_i,
  output logic [DW-1:0]    data_o,
  output logic [LVL_W-1:0] level_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             ovr_o,
  output logic             udr_o
);
  logic [DW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [LVL_W-1:0] level;
  logic             push_ok, pop_ok;

  assign full_o  = (level == LVL_W'(DEPTH));
  assign empty_o = (level == '0);
  assign push_ok = push_i & ~full_o & ~flush_i;
  assign pop_ok  = pop_i & ~empty_o & ~flush_i;
  assign ovr_o   = push_i & full_o & ~flush_i;
  assign udr_o   = pop_i & empty_o & ~flush_i;
  assign data_o  = empty_o ? '0 : mem[rd_ptr];
  assign level_o = level;

  always_ff @(posedge clk_i) begin
    if (push_ok) mem[wr_ptr] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (flush_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
      if (push_ok && !pop_ok)      level <= level + 1'b1;
      else if (pop_ok && !push_ok) level <= level - 1'b1;
    end
  end
endmodule

// File: rtl/i2cfp_trail.sv
module i2cfp_trail #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             armed_i,
  input  logic             activity_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             fire_o
);
  logic [CNT_W-1:0] cnt;
  logic             tick;

  assign tick   = armed_i & ~activity_i;
  // one pulse on the transition into the limit; counter then saturates
  assign fire_o = tick && (limit_i != '0) && ((cnt + 1'b1) == limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt <= '0;
    else if (!tick)           cnt <= '0;
    else if (cnt < limit_i)   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/i2cfp_irq_regs.sv
module i2cfp_irq_regs #(
  parameter int unsigned N = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_we_i,
  input  logic         en_we_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] sts_o,
  output logic [N-1:0] en_o,
  output logic         irq_o
);
  for (genvar i = 0; i < N; i++) begin : g_evt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       sts_o[i] <= 1'b0;
      else if (set_i[i])                 sts_o[i] <= 1'b1;
      else if (clr_we_i && wdata_i[i])   sts_o[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_o <= '0;
    else if (en_we_i) en_o <= wdata_i;
  end

  assign irq_o = |(sts_o & en_o);
endmodule

// File: rtl/i2c_fifo_pair.sv
module i2c_fifo_pair
  import i2cfp_pkg::*;
#(
  parameter int unsigned DEPTH   = 16,
  parameter int unsigned TRAIL_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              tx_pop_i,
  output logic [7:0]        tx_data_o,
  input  logic              rx_push_i,
  input  logic [7:0]        rx_data_i,
  output logic              irq_o
);
  localparam int unsigned LVL_W = $clog2(DEPTH) + 1;

  logic              tx_en, rx_en;
  logic [LVL_FW-1:0] tx_trig, rx_trig;
  logic [TRAIL_W-1:0] trail_lim;

  logic tx_push, rx_pop, ists_we, ien_we;
  logic [LVL_W-1:0] tx_level, rx_level;
  logic [LVL_FW-1:0] tx_lvl, rx_lvl;
  logic tx_full, tx_empty, rx_full, rx_empty;
  logic tx_ovr, tx_udr, rx_ovr, rx_udr, trail_fire;
  logic [7:0] rx_head;
  logic [NUM_EVT-1:0] evt_set, sts, ien;
  logic unused_wdata;

  assign unused_wdata = ^{reg_wdata_i[31:23], reg_wdata_i[15:11], reg_wdata_i[3:2]};

  assign tx_push = reg_we_i & (reg_addr_i == RA_TXD);
  assign rx_pop  = reg_re_i & (reg_addr_i == RA_RXD);
  assign ists_we = reg_we_i & (reg_addr_i == RA_ISTS);
  assign ien_we  = reg_we_i & (reg_addr_i == RA_IEN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_en     <= 1'b0;
      tx_en     <= 1'b0;
      rx_trig   <= '0;
      tx_trig   <= '0;
      trail_lim <= '0;
    end else if (reg_we_i) begin
      if (reg_addr_i == RA_CTRL) begin
        rx_en   <= reg_wdata_i[0];
        tx_en   <= reg_wdata_i[1];
        rx_trig <= reg_wdata_i[4 +: LVL_FW];
        tx_trig <= reg_wdata_i[16 +: LVL_FW];
      end
      if (reg_addr_i == RA_TRAIL) trail_lim <= reg_wdata_i[TRAIL_W-1:0];
    end
  end

  i2cfp_fifo #(.DEPTH(DEPTH), .DW(8)) u_tx_fifo (
    .clk_i, .rst_ni,
    .flush_i (~tx_en),
    .push_i  (tx_push),
    .data_i  (reg_wdata_i[7:0]),
    .pop_i   (tx_pop_i),
    .data_o  (tx_data_o),
    .level_o (tx_level),
    .full_o  (tx_full),
    .empty_o (tx_empty),
    .ovr_o   (tx_ovr),
    .udr_o   (tx_udr)
  );

  i2cfp_fifo #(.DEPTH(DEPTH), .DW(8)) u_rx_fifo (
    .clk_i, .rst_ni,
    .flush_i (~rx_en),
    .push_i  (rx_push_i),
    .data_i  (rx_data_i),
    .pop_i   (rx_pop),
    .data_o  (rx_head),
    .level_o (rx_level),
    .full_o  (rx_full),
    .empty_o (rx_empty),
    .ovr_o   (rx_ovr),
    .udr_o   (rx_udr)
  );

  i2cfp_trail #(.CNT_W(TRAIL_W)) u_trail (
    .clk_i, .rst_ni,
    .armed_i    (rx_en & ~rx_empty),
    .activity_i (rx_push_i | rx_pop),
    .limit_i    (trail_lim),
    .fire_o     (trail_fire)
  );

  assign tx_lvl = LVL_FW'(tx_level);
  assign rx_lvl = LVL_FW'(rx_level);

  always_comb begin
    evt_set            = '0;
    evt_set[EV_TX_AE]  = tx_en & (tx_lvl <= tx_trig);
    evt_set[EV_RX_AF]  = rx_en & (rx_lvl >= rx_trig);
    evt_set[EV_TX_UDR] = tx_udr;
    evt_set[EV_TX_OVR] = tx_ovr;
    evt_set[EV_RX_UDR] = rx_udr;
    evt_set[EV_RX_OVR] = rx_ovr;
    evt_set[EV_TRAIL]  = trail_fire;
  end

  i2cfp_irq_regs #(.N(NUM_EVT)) u_irq (
    .clk_i, .rst_ni,
    .set_i    (evt_set),
    .clr_we_i (ists_we),
    .en_we_i  (ien_we),
    .wdata_i  (reg_wdata_i[NUM_EVT-1:0]),
    .sts_o    (sts),
    .en_o     (ien),
    .irq_o    (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      RA_CTRL: begin
        reg_rdata_o[0]            = rx_en;
        reg_rdata_o[1]            = tx_en;
        reg_rdata_o[4 +: LVL_FW]  = rx_trig;
        reg_rdata_o[16 +: LVL_FW] = tx_trig;
      end
      RA_TRAIL: reg_rdata_o[TRAIL_W-1:0] = trail_lim;
      RA_IEN:   reg_rdata_o[NUM_EVT-1:0] = ien;
      RA_ISTS:  reg_rdata_o[NUM_EVT-1:0] = sts;
      RA_FSTS: begin
        reg_rdata_o[0 +: LVL_FW]  = tx_lvl;
        reg_rdata_o[7]            = tx_full;
        reg_rdata_o[8]            = tx_empty;
        reg_rdata_o[16 +: LVL_FW] = rx_lvl;
        reg_rdata_o[23]           = rx_full;
        reg_rdata_o[24]           = rx_empty;
      end
      RA_RXD:  reg_rdata_o[7:0] = rx_head;
      default: reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/i2cfp_chk.sv
module i2cfp_chk #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned LVL_W = $clog2(DEPTH) + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tx_en,
  input logic             rx_en,
  input logic             tx_push,
  input logic             tx_pop_i,
  input logic             rx_push_i,
  input logic             rx_pop,
  input logic             tx_full,
  input logic             rx_full,
  input logic             tx_empty,
  input logic [7:0]       tx_data_o,
  input logic [LVL_W-1:0] tx_level,
  input logic [LVL_W-1:0] rx_level,
  input logic [6:0]       sts,
  input logic [6:0]       ien,
  input logic             ists_we,
  input logic             irq_o
);
  AST_TX_OVR_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_en && tx_push && tx_full && !tx_pop_i |=> $stable(tx_level) && sts[3]); // R8
  AST_RX_OVR_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_en && rx_push_i && rx_full && !rx_pop |=> $stable(rx_level) && sts[5]); // R8
  AST_TX_UDR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_en && tx_pop_i && tx_empty |-> tx_data_o == 8'h00); // R9
  AST_STS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ists_we |=> (($past(sts) & ~sts) == 7'd0)); // R11
  AST_TX_OFF_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en |=> tx_level == '0); // R4
  AST_RX_OFF_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en |=> rx_level == '0); // R4
  AST_LVL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_level <= LVL_W'(DEPTH) && rx_level <= LVL_W'(DEPTH)); // R5
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ien != 7'd0); // R12
endmodule

bind i2c_fifo_pair i2cfp_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tx_en     (tx_en),
  .rx_en     (rx_en),
  .tx_push   (tx_push),
  .tx_pop_i  (tx_pop_i),
  .rx_push_i (rx_push_i),
  .rx_pop    (rx_pop),
  .tx_full   (tx_full),
  .rx_full   (rx_full),
  .tx_empty  (tx_empty),
  .tx_data_o (tx_data_o),
  .tx_level  (tx_level),
  .rx_level  (rx_level),
  .sts       (sts),
  .ien       (ien),
  .ists_we   (ists_we),
  .irq_o     (irq_o)
);

// File: tb/i2c_fifo_pair_tb_top.sv
module i2c_fifo_pair_tb_top;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0, re = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        tx_pop = 1'b0, rx_push = 1'b0;
  logic [7:0]  tx_data, rx_data = '0;
  logic        irq;
  int          n_chk = 0, n_err = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  i2c_fifo_pair #(.DEPTH(DEPTH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_re_i(re),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .tx_pop_i(tx_pop), .tx_data_o(tx_data), .rx_push_i(rx_push),
    .rx_data_i(rx_data), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic rx_read(output logic [7:0] b);
    @(negedge clk); addr = 3'd6; re = 1'b1; #1 b = rdata[7:0];
    @(negedge clk); re = 1'b0;
  endtask

  task automatic eng_push(input logic [7:0] b);
    @(negedge clk); rx_push = 1'b1; rx_data = b;
    @(negedge clk); rx_push = 1'b0;
  endtask

  task automatic eng_pop(output logic [7:0] b);
    @(negedge clk); tx_pop = 1'b1; #1 b = tx_data;
    @(negedge clk); tx_pop = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    reg_rd(3'd0, d); chk("R1 ctrl", d, 32'h0);
    reg_rd(3'd1, d); chk("R1 trail", d, 32'h0);
    reg_rd(3'd2, d); chk("R1 ien", d, 32'h0);
    reg_rd(3'd3, d); chk("R1 ists", d, 32'h0);
    reg_rd(3'd4, d); chk("R1 R3 fsts", d, 32'h0100_0100);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    reg_wr(3'd1, 32'h1F);
    reg_rd(3'd1, d); chk("R2 trail field", d, 32'hF);
    reg_wr(3'd1, 32'h0);
  endtask

  task automatic t_disabled();
    logic [31:0] d;
    reg_wr(3'd0, 32'h0);
    reg_wr(3'd3, 32'h7F);
    reg_wr(3'd5, 32'hAA);
    eng_push(8'h55);
    repeat (3) @(negedge clk);
    reg_rd(3'd4, d); chk("R4 disabled fsts", d, 32'h0100_0100);
    reg_rd(3'd3, d); chk("R4 disabled no event", d, 32'h0);
  endtask

  task automatic t_tx_ae();
    logic [31:0] d;
    logic [7:0] b;
    reg_wr(3'd0, 32'h0002_0002);
    reg_wr(3'd5, 32'h11); reg_wr(3'd5, 32'h22); reg_wr(3'd5, 32'h33);
    reg_rd(3'd4, d); chk("R3 R5 tx level 3", d, 32'h0100_0003);
    reg_wr(3'd3, 32'h7F);
    reg_rd(3'd3, d); chk("R6 above trigger clear", d & 32'h1, 32'h0);
    eng_pop(b); chk("R5 tx order 1", {24'h0, b}, 32'h11);
    reg_rd(3'd3, d); chk("R6 at trigger set", d & 32'h1, 32'h1);
    eng_pop(b); chk("R5 tx order 2", {24'h0, b}, 32'h22);
    eng_pop(b); chk("R5 tx order 3", {24'h0, b}, 32'h33);
  endtask

  task automatic t_rx_af();
    logic [31:0] d;
    logic [7:0] b;
    reg_wr(3'd0, 32'h0000_0021);
    reg_wr(3'd3, 32'h7F);
    eng_push(8'hA1);
    reg_rd(3'd3, d); chk("R7 below trigger", d & 32'h2, 32'h0);
    eng_push(8'hB2);
    reg_rd(3'd3, d); chk("R7 at trigger", d & 32'h2, 32'h2);
    reg_wr(3'd2, 32'h2);
    @(negedge clk); chk("R12 irq enabled", {31'h0, irq}, 32'h1);
    reg_wr(3'd2, 32'h0);
    @(negedge clk); chk("R12 irq masked", {31'h0, irq}, 32'h0);
    rx_read(b); chk("R5 rx order 1", {24'h0, b}, 32'hA1);
    rx_read(b); chk("R5 rx order 2", {24'h0, b}, 32'hB2);
  endtask

  task automatic t_tx_ovr_udr();
    logic [31:0] d;
    logic [7:0] b;
    reg_wr(3'd0, 32'h0000_0002);
    reg_wr(3'd3, 32'h7F);
    for (int i = 1; i <= DEPTH + 1; i++) reg_wr(3'd5, 32'(i));
    reg_rd(3'd4, d); chk("R8 R3 tx full", d, 32'h0100_0090);
    reg_rd(3'd3, d); chk("R8 tx overrun", d & 32'h8, 32'h8);
    for (int i = 1; i <= DEPTH; i++) eng_pop(b);
    chk("R8 dropped byte", {24'h0, b}, 32'(DEPTH));
    eng_pop(b); chk("R9 tx empty pop zero", {24'h0, b}, 32'h0);
    reg_rd(3'd3, d); chk("R9 tx underrun", d & 32'h4, 32'h4);
    reg_wr(3'd3, 32'h4);
    reg_rd(3'd3, d); chk("R11 partial clear", d & 32'hC, 32'h8);
  endtask

  task automatic t_rx_ovr_udr();
    logic [31:0] d;
    logic [7:0] b;
    reg_wr(3'd0, 32'h0000_0001);
    reg_wr(3'd3, 32'h7F);
    for (int i = 0; i <= DEPTH; i++) eng_push(8'(8'h40 + i));
    reg_rd(3'd4, d); chk("R8 R3 rx full", d, 32'h0090_0100);
    reg_rd(3'd3, d); chk("R8 rx overrun", d & 32'h20, 32'h20);
    for (int i = 0; i < DEPTH; i++) rx_read(b);
    chk("R8 rx last kept", {24'h0, b}, 32'(8'h40 + DEPTH - 1));
    rx_read(b); chk("R9 rx empty pop zero", {24'h0, b}, 32'h0);
    reg_rd(3'd3, d); chk("R9 rx underrun", d & 32'h10, 32'h10);
  endtask

  task automatic t_trailing();
    logic [31:0] d;
    logic [7:0] b;
    reg_wr(3'd0, 32'h0000_0141);
    reg_wr(3'd1, 32'h5);
    reg_wr(3'd3, 32'h7F);
    eng_push(8'h77);
    repeat (3) @(negedge clk);
    reg_rd(3'd3, d); chk("R10 not yet", d & 32'h40, 32'h0);
    reg_rd(3'd3, d); chk("R10 fires at count", d & 32'h40, 32'h40);
    reg_wr(3'd3, 32'h40);
    repeat (20) @(negedge clk);
    reg_rd(3'd3, d); chk("R10 single shot", d & 32'h40, 32'h0);
    rx_read(b); chk("R10 tail byte", {24'h0, b}, 32'h77);
    reg_wr(3'd1, 32'h0);
    eng_push(8'h78);
    reg_wr(3'd3, 32'h40);
    repeat (20) @(negedge clk);
    reg_rd(3'd3, d); chk("R10 zero count never", d & 32'h40, 32'h0);
    rx_read(b);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_disabled();
    t_tx_ae();
    t_rx_af();
    t_tx_ovr_udr();
    t_rx_ovr_udr();
    t_trailing();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule